// File: doc/BRIEF.md
# Reservation Station Scheduler with Tagged Result Bus

This block takes arithmetic operations in program order and hands each one to a reservation station of the matching kind. There are a few stations for an add/subtract unit and a few for a multiply unit. When an operation is accepted, each source register is looked up in a register status table. If no operation in flight will write that register, its value is copied into the station. Otherwise the station stores the number (tag) of the station that will produce it. The destination register is then marked with the new station's tag. Registers are therefore renamed to producer tags, and several loop iterations can be in flight at once.

A station starts its unit once both operands hold values. Until then it watches a single result bus. That bus carries a 64-bit value and the 4-bit tag of the station that produced it. Any station operand or register entry that waits on that tag takes the value. The units are fixed-latency pipelines. A finished result waits in its station until the bus arbiter grants it. The bus carries one result per cycle, and the result that has waited longest goes first. The producing station becomes free at the moment its result is granted.

The surrounding core loads register values through a plain write port and observes registers through a registered read port. Memory buffers are not part of this block.

Top module: `rs_cdb_core`

## Requirements
- R1: An operation is accepted only when a station of its class is free; otherwise `iss_ready` is low and nothing is allocated. Operation codes: 2'b00 add, 2'b01 subtract (src1 minus src2), 2'b10 and 2'b11 multiply. Adder stations carry tags 1 to NUM_ADD, and multiplier stations carry the tags that follow; `iss_tag` shows the tag given.
- R2: Dependent operations get the values that in-order execution would give, whether each source came as a value or as a producer tag.
- R3: A station starts its unit only after both operands hold values. A station waiting on a pending producer cannot broadcast before that producer does.
- R4: Each cycle the result bus carries at most one result: 64 data bits and the nonzero tag of the station that computed it. Every accepted operation is broadcast exactly once with its own tag.
- R5: A register takes a broadcast only if its recorded producer tag equals the broadcast tag. A register that is renamed again keeps the later operation's result, even when the earlier producer finishes last.
- R6: A station is free again in the cycle after its result is granted, so any number of operations can pass through a small set of stations.
- R7: Among finished results, the one that has waited longest is granted first. Equal waits go to the lower station number.
- R8: An operation accepted in the same cycle that its source's producer is on the bus takes the broadcast value directly. It does not keep a tag that will never be broadcast again.
- R9: After reset all stations are free, the bus is idle, every register reads 0 and no register is pending.
- R10: Results wrap modulo 2^64; multiply keeps the low 64 bits of the product.
- R11: A register write through the load port sets the value and clears any pending mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Operation offered this cycle |
| iss_op | input | 2 | Operation code |
| iss_dst | input | IDX_W | Destination register |
| iss_src1 | input | IDX_W | First source register |
| iss_src2 | input | IDX_W | Second source register |
| iss_ready | output | 1 | A station of the required class is free |
| iss_tag | output | TAG_W | Tag of the station that takes the operation |
| ext_we | input | 1 | Register load strobe |
| ext_idx | input | IDX_W | Register to load |
| ext_data | input | DATA_W | Value to load |
| rd_idx | input | IDX_W | Register to observe |
| rd_data | output | DATA_W | Registered value of the observed register |
| rd_busy | output | 1 | Registered pending flag of the observed register |
| cdb_valid | output | 1 | Result bus carries a result |
| cdb_tag | output | TAG_W | Producer tag on the result bus |
| cdb_data | output | DATA_W | Result value on the result bus |

## Verification
The bench uses three adder stations, two multiplier stations, a 2-cycle adder, a 4-cycle multiplier and sixteen registers. The two-cycle latency gap lets an add issued two cycles after a multiply finish in the same cycle as it, which exercises both the tie rule and the age rule of the arbiter. With three adder stations, one pending multiply can hold every adder station and force the structural stall. The slow multiplier also lets a later fast add to the same register finish first, and lets the bench place an issue exactly on the cycle the multiply is broadcast.

// File: rtl/rs_cdb_pkg.sv
package rs_cdb_pkg;
  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_WAIT = 2'd1,
    ST_EXEC = 2'd2,
    ST_DONE = 2'd3
  } st_state_e;

  localparam logic [1:0] OP_ADD = 2'b00;
  localparam logic [1:0] OP_SUB = 2'b01;
endpackage

// File: rtl/rs_cdb_fu.sv
module rs_cdb_fu #(
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4,
  parameter int LAT    = 2,
  parameter int IS_MUL = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [TAG_W-1:0]  start_tag,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              done,
  output logic [TAG_W-1:0]  done_tag,
  output logic [DATA_W-1:0] done_data
);
  logic [DATA_W-1:0] res;
  logic [LAT-1:0]    vld;
  logic [TAG_W-1:0]  tg [LAT];
  logic [DATA_W-1:0] dt [LAT];

  generate
    if (IS_MUL != 0) begin : g_mul
      assign res = opa * opb;
    end else begin : g_add
      assign res = opa + opb;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      vld[0] <= start;
      for (int i = 1; i < LAT; i++) vld[i] <= vld[i-1];
    end
  end

  always_ff @(posedge clk) begin
    tg[0] <= start_tag;
    dt[0] <= res;
    for (int i = 1; i < LAT; i++) begin
      tg[i] <= tg[i-1];
      dt[i] <= dt[i-1];
    end
  end

  assign done      = vld[LAT-1];
  assign done_tag  = tg[LAT-1];
  assign done_data = dt[LAT-1];
endmodule

// File: rtl/rs_cdb_station.sv
module rs_cdb_station
  import rs_cdb_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4,
  parameter int AGE_W  = 3,
  parameter int MY_TAG = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc,
  input  logic              alloc_sub,
  input  logic [DATA_W-1:0] alloc_v1,
  input  logic [TAG_W-1:0]  alloc_q1,
  input  logic [DATA_W-1:0] alloc_v2,
  input  logic [TAG_W-1:0]  alloc_q2,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  input  logic              disp_go,
  input  logic              fu_done,
  input  logic [TAG_W-1:0]  fu_tag,
  input  logic [DATA_W-1:0] fu_data,
  input  logic              bc_grant,
  output logic              busy,
  output logic              ready,
  output logic              done,
  output logic [AGE_W-1:0]  age,
  output logic [DATA_W-1:0] res,
  output logic [DATA_W-1:0] op_a,
  output logic [DATA_W-1:0] op_b
);
  st_state_e         state;
  logic              sub;
  logic [DATA_W-1:0] v1, v2;
  logic [TAG_W-1:0]  q1, q2;
  logic              hit1, hit2;

  assign hit1 = cdb_valid && (q1 != '0) && (q1 == cdb_tag);
  assign hit2 = cdb_valid && (q2 != '0) && (q2 == cdb_tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FREE;
      sub   <= 1'b0;
      v1    <= '0;
      v2    <= '0;
      q1    <= '0;
      q2    <= '0;
      age   <= '0;
      res   <= '0;
    end else begin
      case (state)
        ST_FREE: if (alloc) begin
          state <= ST_WAIT;
          sub   <= alloc_sub;
          v1    <= alloc_v1;
          q1    <= alloc_q1;
          v2    <= alloc_v2;
          q2    <= alloc_q2;
        end
        ST_WAIT: begin
          if (hit1) begin
            v1 <= cdb_data;
            q1 <= '0;
          end
          if (hit2) begin
            v2 <= cdb_data;
            q2 <= '0;
          end
          if (disp_go) state <= ST_EXEC;
        end
        ST_EXEC: if (fu_done && fu_tag == TAG_W'(MY_TAG)) begin
          res   <= fu_data;
          age   <= '0;
          state <= ST_DONE;
        end
        default: begin
          if (bc_grant) state <= ST_FREE;
          else if (age != '1) age <= age + 1'b1;
        end
      endcase
    end
  end

  assign busy  = (state != ST_FREE);
  assign ready = (state == ST_WAIT) && (q1 == '0) && (q2 == '0);
  assign done  = (state == ST_DONE);
  assign op_a  = v1;
  assign op_b  = sub ? (~v2 + 1'b1) : v2;

  // R1: allocation only lands on a free station
  assert_alloc_free_R1: assert property (@(posedge clk) disable iff (rst)
    alloc |-> state == ST_FREE);
  // R3: a waiting operand picks up a matching broadcast
  assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && hit1) |=> (q1 == '0 && v1 == $past(cdb_data)));
  // R6: a granted station is free on the next cycle
  assert_free_after_bcast_R6: assert property (@(posedge clk) disable iff (rst)
    bc_grant |=> state == ST_FREE);
  // R4: a held result does not change while waiting for the bus
  assert_result_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE && !bc_grant) |=> $stable(res));
endmodule

// File: rtl/rs_cdb_regs.sv
module rs_cdb_regs #(
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4,
  parameter int NREG   = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_we,
  input  logic [IDX_W-1:0]  iss_dst,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic [IDX_W-1:0]  src1,
  input  logic [IDX_W-1:0]  src2,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  input  logic              ext_we,
  input  logic [IDX_W-1:0]  ext_idx,
  input  logic [DATA_W-1:0] ext_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] s1_val,
  output logic [TAG_W-1:0]  s1_tag,
  output logic [DATA_W-1:0] s2_val,
  output logic [TAG_W-1:0]  s2_tag,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_busy
);
  logic [DATA_W-1:0] rf [NREG];
  logic [TAG_W-1:0]  qt [NREG];

  always_comb begin
    s1_val = rf[src1];
    s1_tag = qt[src1];
    s2_val = rf[src2];
    s2_tag = qt[src2];
    if (cdb_valid && s1_tag != '0 && s1_tag == cdb_tag) begin
      s1_val = cdb_data;
      s1_tag = '0;
    end
    if (cdb_valid && s2_tag != '0 && s2_tag == cdb_tag) begin
      s2_val = cdb_data;
      s2_tag = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREG; r++) begin
        rf[r] <= '0;
        qt[r] <= '0;
      end
      rd_data <= '0;
      rd_busy <= 1'b0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (cdb_valid && qt[r] != '0 && qt[r] == cdb_tag) begin
          rf[r] <= cdb_data;
          qt[r] <= '0;
        end
        if (ext_we && ext_idx == IDX_W'(r)) begin
          rf[r] <= ext_data;
          qt[r] <= '0;
        end
        if (iss_we && iss_dst == IDX_W'(r)) qt[r] <= iss_tag;
      end
      rd_data <= rf[rd_idx];
      rd_busy <= (qt[rd_idx] != '0);
    end
  end

  generate
    for (genvar r = 0; r < NREG; r++) begin : g_chk
      // R5: a broadcast for another producer leaves the register value alone
      assert_latest_only_R5: assert property (@(posedge clk) disable iff (rst)
        (cdb_valid && qt[r] != cdb_tag && !(ext_we && ext_idx == IDX_W'(r)))
        |=> rf[r] == $past(rf[r]));
    end
  endgenerate
endmodule

// File: rtl/rs_cdb_core.sv
module rs_cdb_core
  import rs_cdb_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int TAG_W    = 4,
  parameter int NUM_ADD  = 3,
  parameter int NUM_MUL  = 2,
  parameter int ADD_LAT  = 2,
  parameter int MUL_LAT  = 4,
  parameter int AGE_W    = 3,
  parameter int NUM_REGS = 16,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic [1:0]        iss_op,
  input  logic [IDX_W-1:0]  iss_dst,
  input  logic [IDX_W-1:0]  iss_src1,
  input  logic [IDX_W-1:0]  iss_src2,
  output logic              iss_ready,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic              ext_we,
  input  logic [IDX_W-1:0]  ext_idx,
  input  logic [DATA_W-1:0] ext_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_busy,
  output logic              cdb_valid,
  output logic [TAG_W-1:0]  cdb_tag,
  output logic [DATA_W-1:0] cdb_data
);
  localparam int NUM_ST = NUM_ADD + NUM_MUL;

  logic              st_busy  [NUM_ST];
  logic              st_ready [NUM_ST];
  logic              st_done  [NUM_ST];
  logic [AGE_W-1:0]  st_age   [NUM_ST];
  logic [DATA_W-1:0] st_res   [NUM_ST];
  logic [DATA_W-1:0] st_a     [NUM_ST];
  logic [DATA_W-1:0] st_b     [NUM_ST];
  logic              st_fdone [NUM_ST];
  logic [TAG_W-1:0]  st_ftag  [NUM_ST];
  logic [DATA_W-1:0] st_fdata [NUM_ST];
  logic [NUM_ST-1:0] alloc, disp, grant;

  logic              want_mul, issue_fire;
  int                sel_idx;
  logic [DATA_W-1:0] s1_val, s2_val;
  logic [TAG_W-1:0]  s1_tag, s2_tag;

  // issue: lowest free station of the required class
  assign want_mul = iss_op[1];
  always_comb begin
    iss_ready = 1'b0;
    sel_idx   = 0;
    for (int i = 0; i < NUM_ST; i++) begin
      if (!iss_ready && !st_busy[i] && ((i >= NUM_ADD) == want_mul)) begin
        iss_ready = 1'b1;
        sel_idx   = i;
      end
    end
  end
  assign iss_tag    = TAG_W'(sel_idx + 1);
  assign issue_fire = iss_valid && iss_ready;

  always_comb begin
    for (int i = 0; i < NUM_ST; i++) alloc[i] = issue_fire && (sel_idx == i);
  end

  rs_cdb_regs #(
    .DATA_W(DATA_W), .TAG_W(TAG_W), .NREG(NUM_REGS), .IDX_W(IDX_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .iss_we(issue_fire), .iss_dst(iss_dst), .iss_tag(iss_tag),
    .src1(iss_src1), .src2(iss_src2),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .ext_we(ext_we), .ext_idx(ext_idx), .ext_data(ext_data),
    .rd_idx(rd_idx),
    .s1_val(s1_val), .s1_tag(s1_tag), .s2_val(s2_val), .s2_tag(s2_tag),
    .rd_data(rd_data), .rd_busy(rd_busy)
  );

  // dispatch: lowest ready station per unit
  logic              add_go, mul_go;
  int                add_idx, mul_idx;
  always_comb begin
    add_go = 1'b0; mul_go = 1'b0;
    add_idx = 0;   mul_idx = NUM_ADD;
    for (int i = 0; i < NUM_ST; i++) begin
      if (st_ready[i]) begin
        if (i < NUM_ADD) begin
          if (!add_go) begin add_go = 1'b1; add_idx = i; end
        end else begin
          if (!mul_go) begin mul_go = 1'b1; mul_idx = i; end
        end
      end
    end
    for (int i = 0; i < NUM_ST; i++)
      disp[i] = (add_go && add_idx == i) || (mul_go && mul_idx == i);
  end

  logic              add_done, mul_done;
  logic [TAG_W-1:0]  add_dtag, mul_dtag;
  logic [DATA_W-1:0] add_ddata, mul_ddata;

  rs_cdb_fu #(.DATA_W(DATA_W), .TAG_W(TAG_W), .LAT(ADD_LAT), .IS_MUL(0)) u_add (
    .clk(clk), .rst(rst), .start(add_go), .start_tag(TAG_W'(add_idx + 1)),
    .opa(st_a[add_idx]), .opb(st_b[add_idx]),
    .done(add_done), .done_tag(add_dtag), .done_data(add_ddata)
  );

  rs_cdb_fu #(.DATA_W(DATA_W), .TAG_W(TAG_W), .LAT(MUL_LAT), .IS_MUL(1)) u_mul (
    .clk(clk), .rst(rst), .start(mul_go), .start_tag(TAG_W'(mul_idx + 1)),
    .opa(st_a[mul_idx]), .opb(st_b[mul_idx]),
    .done(mul_done), .done_tag(mul_dtag), .done_data(mul_ddata)
  );

  always_comb begin
    for (int i = 0; i < NUM_ST; i++) begin
      st_fdone[i] = (i < NUM_ADD) ? add_done  : mul_done;
      st_ftag[i]  = (i < NUM_ADD) ? add_dtag  : mul_dtag;
      st_fdata[i] = (i < NUM_ADD) ? add_ddata : mul_ddata;
    end
  end

  generate
    for (genvar g = 0; g < NUM_ST; g++) begin : g_st
      rs_cdb_station #(
        .DATA_W(DATA_W), .TAG_W(TAG_W), .AGE_W(AGE_W), .MY_TAG(g + 1)
      ) u_st (
        .clk(clk), .rst(rst),
        .alloc(alloc[g]), .alloc_sub(iss_op == OP_SUB),
        .alloc_v1(s1_val), .alloc_q1(s1_tag),
        .alloc_v2(s2_val), .alloc_q2(s2_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .disp_go(disp[g]),
        .fu_done(st_fdone[g]), .fu_tag(st_ftag[g]), .fu_data(st_fdata[g]),
        .bc_grant(grant[g]),
        .busy(st_busy[g]), .ready(st_ready[g]), .done(st_done[g]),
        .age(st_age[g]), .res(st_res[g]), .op_a(st_a[g]), .op_b(st_b[g])
      );
    end
  endgenerate

  // bus arbiter: longest wait first, lower station on ties
  logic             win_found;
  int               win;
  logic [AGE_W-1:0] best;
  always_comb begin
    win_found = 1'b0;
    win       = 0;
    best      = '0;
    for (int i = 0; i < NUM_ST; i++) begin
      if (st_done[i] && (!win_found || st_age[i] > best)) begin
        win_found = 1'b1;
        win       = i;
        best      = st_age[i];
      end
    end
    for (int i = 0; i < NUM_ST; i++) grant[i] = win_found && (win == i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cdb_valid <= 1'b0;
      cdb_tag   <= '0;
      cdb_data  <= '0;
    end else begin
      cdb_valid <= win_found;
      cdb_tag   <= TAG_W'(win + 1);
      cdb_data  <= st_res[win];
    end
  end

  // R4: a broadcast always names a real station
  assert_cdb_tag_R4: assert property (@(posedge clk) disable iff (rst)
    cdb_valid |-> (cdb_tag != '0 && cdb_tag <= TAG_W'(NUM_ST)));
endmodule

// File: tb/rs_cdb_core_tb.sv
`timescale 1ns/1ps
module rs_cdb_core_tb;
  localparam int DW = 64, TW = 4, NR = 16, IW = 4, NA = 3, NM = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          iss_valid;
  logic [1:0]    iss_op;
  logic [IW-1:0] iss_dst, iss_src1, iss_src2;
  logic          iss_ready;
  logic [TW-1:0] iss_tag;
  logic          ext_we;
  logic [IW-1:0] ext_idx;
  logic [DW-1:0] ext_data;
  logic [IW-1:0] rd_idx;
  logic [DW-1:0] rd_data;
  logic          rd_busy;
  logic          cdb_valid;
  logic [TW-1:0] cdb_tag;
  logic [DW-1:0] cdb_data;

  always #10 clk = ~clk;

  rs_cdb_core #(
    .DATA_W(DW), .TAG_W(TW), .NUM_ADD(NA), .NUM_MUL(NM),
    .ADD_LAT(2), .MUL_LAT(4), .AGE_W(3), .NUM_REGS(NR)
  ) u_dut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
    .iss_ready(iss_ready), .iss_tag(iss_tag),
    .ext_we(ext_we), .ext_idx(ext_idx), .ext_data(ext_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .rd_busy(rd_busy),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data)
  );

  typedef struct { logic [TW-1:0] tag; logic [DW-1:0] data; } exp_t;
  exp_t          expq[$];
  logic [TW-1:0] tlog[$];
  logic [DW-1:0] arch [NR];
  int            checks = 0, fails = 0, niss = 0, nbc = 0;
  logic [TW-1:0] last_tag;
  bit            ended = 0;

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor: pop the expected item for the broadcast tag
  always @(negedge clk) begin
    int k;
    if (!rst && cdb_valid) begin
      k = -1;
      for (int i = 0; i < expq.size(); i++)
        if (k < 0 && expq[i].tag == cdb_tag) k = i;
      tlog.push_back(cdb_tag);
      nbc++;
      if (k < 0) check(1'b0, "R4 unexpected tag", DW'(cdb_tag), '0);
      else begin
        check(cdb_data == expq[k].data, "R2/R10 broadcast data", cdb_data, expq[k].data);
        expq.delete(k);
      end
    end
  end

  // driver: offer one operation, push its expected result
  task automatic do_iss(input logic [1:0] op, input int d, input int s1, input int s2);
    logic [DW-1:0] r;
    iss_valid = 1'b1; iss_op = op;
    iss_dst = IW'(d); iss_src1 = IW'(s1); iss_src2 = IW'(s2);
    #1;
    while (!iss_ready) begin @(negedge clk); #1; end
    if (op[1]) r = arch[s1] * arch[s2];
    else if (op[0]) r = arch[s1] - arch[s2];
    else r = arch[s1] + arch[s2];
    if (op[1]) check(iss_tag > NA && iss_tag <= NA + NM, "R1 multiplier class tag", DW'(iss_tag), NA + 1);
    else check(iss_tag >= 1 && iss_tag <= NA, "R1 adder class tag", DW'(iss_tag), 1);
    expq.push_back('{iss_tag, r});
    arch[d] = r;
    last_tag = iss_tag;
    niss++;
    @(posedge clk); #1 iss_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic ext_wr(input int i, input logic [DW-1:0] v);
    ext_we = 1'b1; ext_idx = IW'(i); ext_data = v; arch[i] = v;
    @(negedge clk);
    ext_we = 1'b0;
  endtask

  task automatic rdchk(input int i, input string req);
    rd_idx = IW'(i);
    @(negedge clk);
    check(rd_data == arch[i], req, rd_data, arch[i]);
    check(rd_busy == 1'b0, req, DW'(rd_busy), '0);
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      checks++; fails++;
      $display("FAIL watchdog R3 actual=hung expected=drained");
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    logic [TW-1:0] tm, ta1, ta2;
    rst = 1'b1; iss_valid = 1'b0; iss_op = '0; iss_dst = '0; iss_src1 = '0; iss_src2 = '0;
    ext_we = 1'b0; ext_idx = '0; ext_data = '0; rd_idx = '0;
    for (int i = 0; i < NR; i++) arch[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9 reset state
    check(cdb_valid == 1'b0, "R9 bus idle", DW'(cdb_valid), '0);
    iss_op = 2'b00; #1 check(iss_ready == 1'b1, "R9 adder station free", DW'(iss_ready), 1);
    iss_op = 2'b10; #1 check(iss_ready == 1'b1, "R9 multiplier station free", DW'(iss_ready), 1);
    iss_op = 2'b00;
    rdchk(3, "R9 register reset");

    // R11 preload
    ext_wr(1, 64'hFFFF_FFFF_FFFF_FFF0);
    for (int i = 2; i < NR; i++) ext_wr(i, DW'(i) * 64'h0000_0123_4567_89AB + DW'(i));
    rdchk(2, "R11 loaded value");

    // R10 independent arithmetic with wrap
    do_iss(2'b00, 8, 1, 2);
    do_iss(2'b01, 9, 3, 4);
    do_iss(2'b10, 10, 1, 2);
    do_iss(2'b11, 11, 4, 5);
    drain();
    rdchk(9, "R10 subtract wrap");

    // R2 dependent chain, destination equal to source
    do_iss(2'b10, 8, 8, 3);
    do_iss(2'b00, 9, 8, 9);
    do_iss(2'b01, 10, 9, 8);
    do_iss(2'b00, 3, 3, 3);
    drain();
    rdchk(10, "R2 dependent chain");

    // R1 structural stall and R3 waiting order
    base = tlog.size();
    do_iss(2'b10, 11, 1, 2);
    tm = last_tag;
    do_iss(2'b00, 12, 11, 1);
    do_iss(2'b00, 13, 11, 2);
    do_iss(2'b00, 14, 11, 3);
    iss_valid = 1'b1; iss_op = 2'b00; iss_dst = 4'd15;
    #1 check(iss_ready == 1'b0, "R1 stall when adder stations full", DW'(iss_ready), 0);
    iss_op = 2'b10;
    #1 check(iss_ready == 1'b1, "R1 multiplier class unaffected", DW'(iss_ready), 1);
    iss_valid = 1'b0;
    @(negedge clk);
    do_iss(2'b00, 15, 12, 13);
    drain();
    check(tlog[base] == tm, "R3 waiting stations broadcast after producer", DW'(tlog[base]), DW'(tm));
    rdchk(15, "R3 chained result");

    // R5 register renamed twice, earlier producer finishes last
    base = tlog.size();
    do_iss(2'b10, 5, 1, 2);
    tm = last_tag;
    do_iss(2'b00, 5, 3, 4);
    drain();
    check(tlog[base + 1] == tm, "R5 slow producer finished last", DW'(tlog[base + 1]), DW'(tm));
    rdchk(5, "R5 latest producer kept");

    // R7 oldest finished result first, ties to lower station
    base = tlog.size();
    do_iss(2'b10, 12, 2, 3);
    tm = last_tag;
    @(negedge clk);
    do_iss(2'b00, 13, 3, 4);
    ta1 = last_tag;
    do_iss(2'b00, 14, 4, 6);
    ta2 = last_tag;
    drain();
    check(tlog[base] == ta1, "R7 tie to lower station", DW'(tlog[base]), DW'(ta1));
    check(tlog[base + 1] == tm, "R7 longest wait first", DW'(tlog[base + 1]), DW'(tm));
    check(tlog[base + 2] == ta2, "R7 younger result last", DW'(tlog[base + 2]), DW'(ta2));

    // R8 issue in the broadcast cycle of its producer
    do_iss(2'b10, 6, 1, 2);
    tm = last_tag;
    while (!(cdb_valid && cdb_tag == tm)) @(negedge clk);
    do_iss(2'b00, 7, 6, 1);
    drain();
    rdchk(7, "R8 same cycle bypass");

    // R6 station reuse
    for (int i = 0; i < 8; i++) do_iss(2'b00, 1 + (i % 4), 1 + (i % 4), 9);
    for (int i = 0; i < 4; i++) do_iss(2'b10, 11 + (i % 2), 11 + (i % 2), 2);
    drain();
    check(nbc == niss && expq.size() == 0, "R6 every operation broadcast once", DW'(nbc), DW'(niss));

    for (int i = 1; i < NR; i++) rdchk(i, "R2 final register");

    ended = 1;
    summary();
    $finish;
  end
endmodule